// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is a watchdog timer that counts ticks of a slow oscillator, delivered as a one-cycle clock enable on the system clock. A prescaler counter picks one of ten time-out lengths, from 2^TAP_BASE ticks up to 2^(TAP_BASE+9) ticks, each step doubling the one before. When the selected count is reached, the block does one of two things. It can raise a one-cycle reset pulse, or it can set a sticky interrupt flag so the timer can serve as a wake-up source. Software keeps the timer from expiring by pulsing the kick input, which restarts the count.

A static fuse input picks one of two protection levels. At level 1 the timer starts stopped. It may be started, retimed or switched to interrupt mode at any time. Stopping it once it runs requires an unlock step. At level 2 the timer always runs. Changing its period or its interrupt mode requires the unlock step. The unlock step is a write of the signature byte to the unlock register. That write opens a window of WIN_CYCLES clock cycles. The window closes early on the first control write.

The register port is a plain single-cycle write strobe with an address bit and a combinational read. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure: every write is taken at the clock edge where `bus_wr` is high. The fuse must only change while `rst_n` is low.

Top module: `wdt_guard`

## Requirements
- R1: After reset the control register reads 0x00 at level 1 and 0x01 at level 2, the unlock register reads 0x00, both outputs are low, and a stopped timer never times out.
- R2: With period code c in 0..9, the reset pulse rises exactly 2^(TAP_BASE+c) oscillator ticks after the clock edge that restarted the count. It lasts one clock cycle. Only cycles with `osc_tick` high advance the count.
- R3: Period codes 10 to 15 behave like code 9, the longest time-out.
- R4: A kick clears the count, so the next time-out comes a full period after the kick.
- R5: With the interrupt-mode bit set, a time-out sets the flag (ctrl bit 2, driven on `wdt_irq`) and gives no reset pulse. The flag stays set until a control write with bit 2 at one. Writing zero to bit 2 leaves it set.
- R6: At level 1 a control write without unlock may set the run bit (bit 0) and change the interrupt-mode bit (bit 1) and the period code (bits 6:3), also while the timer runs.
- R7: At level 1 a control write with bit 0 at zero, made without an open window, leaves a running timer running. The other fields of that write still take effect.
- R8: A window opened at edge E accepts a control write at edges E+1 to E+WIN_CYCLES. A write at E+WIN_CYCLES+1 is treated as unprotected.
- R9: Writing any byte other than the signature (default 0xD8) to the unlock register (address 0) opens no window.
- R10: The first control write (address 1) after the signature closes the window, so a second write is unprotected.
- R11: At level 2, bit 0 always reads one and the timer always runs. Without an open window, control writes leave the period code and the interrupt-mode bit unchanged.
- R12: At level 2, a control write inside the window updates the period code and the interrupt-mode bit, and the value written to bit 0 has no effect.
- R13: Reading the unlock register returns the window state in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per slow-oscillator period |
| fuse_lvl2 | input | 1 | Static protection level select: 0 = level 1, 1 = level 2 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = unlock, 1 = control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| kick | input | 1 | Restart the time-out count |
| wdt_reset | output | 1 | One-cycle reset request on time-out |
| wdt_irq | output | 1 | Sticky time-out interrupt flag |

## Verification
The time-out is tried with every period code, 0 to 15, each started by a write that also kicks. This separates a correct tap decode from an off-by-one count, and it shows that reserved codes fall back to the longest tap rather than to a short one. A toggling tick pattern separates counting by oscillator ticks from counting by clock cycles. A kick partway through a period separates a restarted count from a count that merely continues. The protection rules are tried with writes at the last and first-too-late window edges, with a wrong signature, and with a double write after one signature. Together these tell a window that is too long, too short or reusable from a correct one, at both levels.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // register select on the one-bit address
  typedef enum logic {
    REG_UNLOCK = 1'b0,
    REG_CTRL   = 1'b1
  } reg_sel_e;

  localparam int DATA_W     = 8;
  localparam int PER_W      = 4;
  // control register field positions
  localparam int BIT_RUN    = 0;
  localparam int BIT_IE     = 1;
  localparam int BIT_FLAG   = 2;
  localparam int BIT_PER_LO = 3;
endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock
  import wdg_pkg::*;
#(
  parameter logic [DATA_W-1:0] SIGNATURE  = 8'hD8,
  parameter int                WIN_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              win_open
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_CYCLES);

  logic [CW-1:0] win_cnt;
  logic          sig_hit;
  logic          bad_sig;
  logic          ctrl_hit;

  assign sig_hit  = wr && (addr == REG_UNLOCK) && (wdata == SIGNATURE);
  assign bad_sig  = wr && (addr == REG_UNLOCK) && (wdata != SIGNATURE);
  assign ctrl_hit = wr && (addr == REG_CTRL);
  assign win_open = (win_cnt != '0);

  // window counter: load on signature, drop on any control write, else count down
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (sig_hit) begin
      win_cnt <= WIN_LOAD;
    end else if (ctrl_hit) begin
      win_cnt <= '0;
    end else if (win_cnt != '0) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt <= WIN_LOAD); // R8
  AST_WIN_LIFETIME: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(win_cnt) == CW'(1)) && !$past(sig_hit) |-> !win_open); // R8
  AST_WIN_SHUT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_hit) |-> !win_open); // R10
  AST_BAD_SIG_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bad_sig) && !$past(win_open) |-> !win_open); // R9
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
  import wdg_pkg::*;
#(
  parameter int TAP_BASE = 11,
  parameter int NUM_TAPS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             kick,
  input  logic [PER_W-1:0] period,
  output logic             timeout
);
  localparam int CNT_W = TAP_BASE + NUM_TAPS - 1;
  localparam int SLOTS = 2 ** PER_W;
  localparam logic [PER_W-1:0] TOP_CODE = PER_W'(NUM_TAPS - 1);

  logic [CNT_W-1:0] cnt;
  logic [SLOTS-1:0] reach;
  logic [PER_W-1:0] sel;

  // one comparator per tap; code slots past the last tap never fire
  for (genvar k = 0; k < SLOTS; k++) begin : g_tap
    if (k < NUM_TAPS) begin : g_live
      localparam logic [CNT_W-1:0] LIM = CNT_W'((64'd1 << (TAP_BASE + k)) - 64'd1);
      assign reach[k] = (cnt >= LIM);
    end else begin : g_pad
      assign reach[k] = 1'b0;
    end
  end

  // reserved codes fold onto the longest tap
  assign sel     = (period > TOP_CODE) ? TOP_CODE : period;
  assign timeout = tick && run && !kick && reach[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || kick) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= timeout ? '0 : cnt + 1'b1;
    end
  end

  AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !timeout); // R4
  AST_RESERVED_LONGEST: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && (period > TOP_CODE) |-> (&cnt)); // R3
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fuse_lvl2,
  input  logic             ctrl_wr,
  input  logic             wr_run,
  input  logic             wr_ie,
  input  logic             wr_flag,
  input  logic [PER_W-1:0] wr_per,
  input  logic             win_open,
  input  logic             timeout,
  output logic             run_eff,
  output logic             irq_en,
  output logic             irq_flag,
  output logic [PER_W-1:0] period
);
  logic             run_q;
  logic             ie_q;
  logic             flag_q;
  logic [PER_W-1:0] per_q;
  logic             flag_clr;

  assign flag_clr = ctrl_wr && wr_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
      per_q <= '0;
    end else if (ctrl_wr) begin
      if (fuse_lvl2) begin
        // level 2: everything that matters is guarded, run bit ignored
        if (win_open) begin
          per_q <= wr_per;
          ie_q  <= wr_ie;
        end
      end else begin
        // level 1: only stopping a running timer is guarded
        per_q <= wr_per;
        ie_q  <= wr_ie;
        if (wr_run) begin
          run_q <= 1'b1;
        end else if (win_open) begin
          run_q <= 1'b0;
        end
      end
    end
  end

  // sticky flag, set wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (timeout && ie_q) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign run_eff  = fuse_lvl2 | run_q;
  assign irq_en   = ie_q;
  assign irq_flag = flag_q;
  assign period   = per_q;

  AST_L1_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !fuse_lvl2 && $past(run_q) && !$past(win_open) |-> run_q); // R7
  AST_L2_PERIOD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_lvl2 && !$past(win_open) |-> $stable(per_q) && $stable(ie_q)); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_q) && !$past(flag_clr) |-> flag_q); // R5
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdg_pkg::*;
#(
  parameter logic [DATA_W-1:0] SIGNATURE  = 8'hD8,
  parameter int                WIN_CYCLES = 4,
  parameter int                TAP_BASE   = 11,
  parameter int                NUM_TAPS   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              fuse_lvl2,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kick,
  output logic              wdt_reset,
  output logic              wdt_irq
);
  logic             win_open;
  logic             ctrl_wr;
  logic             run_eff;
  logic             irq_en;
  logic             irq_flag;
  logic [PER_W-1:0] period;
  logic             timeout;
  logic             rst_q;

  assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL);

  wdg_unlock #(
    .SIGNATURE (SIGNATURE),
    .WIN_CYCLES(WIN_CYCLES)
  ) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .win_open(win_open)
  );

  wdg_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .fuse_lvl2(fuse_lvl2),
    .ctrl_wr  (ctrl_wr),
    .wr_run   (bus_wdata[BIT_RUN]),
    .wr_ie    (bus_wdata[BIT_IE]),
    .wr_flag  (bus_wdata[BIT_FLAG]),
    .wr_per   (bus_wdata[BIT_PER_LO +: PER_W]),
    .win_open (win_open),
    .timeout  (timeout),
    .run_eff  (run_eff),
    .irq_en   (irq_en),
    .irq_flag (irq_flag),
    .period   (period)
  );

  wdg_prescaler #(
    .TAP_BASE(TAP_BASE),
    .NUM_TAPS(NUM_TAPS)
  ) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (osc_tick),
    .run    (run_eff),
    .kick   (kick),
    .period (period),
    .timeout(timeout)
  );

  // reset request only when interrupt mode is off
  always_ff @(posedge clk) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= timeout && !irq_en;
  end

  assign wdt_reset = rst_q;
  assign wdt_irq   = irq_flag;

  assign bus_rdata = (bus_addr == REG_CTRL)
                   ? {1'b0, period, irq_flag, irq_en, run_eff}
                   : {{(DATA_W-1){1'b0}}, win_open};

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset |=> !wdt_reset); // R2
  AST_IRQ_NOT_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> !wdt_reset); // R5
  AST_L2_READS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_lvl2 && (bus_addr == REG_CTRL) |-> bus_rdata[BIT_RUN]); // R11
endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
  import wdg_pkg::*;

  localparam int TB_BASE = 2;
  localparam logic [7:0] SIG = 8'hD8;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n, osc_tick, fuse_lvl2, bus_wr, bus_addr, kick;
  logic [7:0] bus_wdata, bus_rdata;
  logic       wdt_reset, wdt_irq;
  logic       tick_alt;
  int         n_chk = 0;
  int         n_bad = 0;
  int         pulse_cnt = 0;

  // period code, expected latency in clock edges (tick every cycle)
  localparam logic [15:0] VEC [16] = '{
    {4'd0, 12'd4},    {4'd1, 12'd8},    {4'd2, 12'd16},   {4'd3, 12'd32},
    {4'd4, 12'd64},   {4'd5, 12'd128},  {4'd6, 12'd256},  {4'd7, 12'd512},
    {4'd8, 12'd1024}, {4'd9, 12'd2048}, {4'd10, 12'd2048}, {4'd11, 12'd2048},
    {4'd12, 12'd2048}, {4'd13, 12'd2048}, {4'd14, 12'd2048}, {4'd15, 12'd2048}
  };

  wdt_guard #(.SIGNATURE(SIG), .WIN_CYCLES(4), .TAP_BASE(TB_BASE), .NUM_TAPS(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fuse_lvl2(fuse_lvl2),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kick(kick), .wdt_reset(wdt_reset), .wdt_irq(wdt_irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    osc_tick <= tick_alt ? ~osc_tick : 1'b1;
    if (wdt_reset) pulse_cnt <= pulse_cnt + 1;
  end

  function automatic logic [7:0] ctl(input logic [3:0] per, input logic ie,
                                     input logic run, input logic fl);
    return {1'b0, per, fl, ie, run};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic k);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; kick = k;
    @(negedge clk);
    bus_wr = 1'b0; kick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!wdt_reset && n < 5000);
    check(req, n, exp);
    @(posedge clk); #1;
    check({req, " pulse width"}, int'(wdt_reset), 0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int pc, lat;
    rst_n = 0; fuse_lvl2 = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    kick = 0; tick_alt = 0; osc_tick = 1;
    idle(3);
    rst_n = 1;

    // R1 reset state at level 1
    rd(REG_CTRL, v);   check("R1 ctrl", v, 8'h00);
    rd(REG_UNLOCK, v); check("R1 unlock", v, 8'h00);
    check("R1 reset out", wdt_reset, 0);
    check("R1 irq out", wdt_irq, 0);
    idle(20);
    check("R1 stopped no timeout", pulse_cnt, 0);

    // R6 start freely
    wr(REG_CTRL, ctl(4'd5, 0, 1, 0), 0);
    rd(REG_CTRL, v); check("R6 start", v, ctl(4'd5, 0, 1, 0));

    // table walk: R2, R3, R6
    for (int i = 0; i < 16; i++) begin
      wr(REG_CTRL, ctl(VEC[i][15:12], 0, 1, 0), 1);
      rd(REG_CTRL, v); check("R6 period change", v, ctl(VEC[i][15:12], 0, 1, 0));
      lat = int'(VEC[i][11:0]);
      if (i < 10) measure("R2 latency", lat);
      else        measure("R3 reserved latency", lat);
    end

    // R4 kick restarts
    wr(REG_CTRL, ctl(4'd0, 0, 1, 0), 1);
    pc = pulse_cnt;
    idle(2);
    kick = 1; @(negedge clk); kick = 0;
    check("R4 no early pulse", pulse_cnt, pc);
    measure("R4 latency after kick", 4);

    // R2 ticks gate the count
    tick_alt = 1;
    wr(REG_CTRL, ctl(4'd0, 0, 1, 0), 1);
    begin
      int n = 0;
      do begin @(posedge clk); #1; n++; end while (!wdt_reset && n < 5000);
      check("R2 tick gating", int'(n == 7 || n == 8), 1);
    end
    @(negedge clk);
    tick_alt = 0;
    idle(2);

    // R7 unprotected stop ignored, other fields taken
    wr(REG_CTRL, ctl(4'd2, 0, 1, 0), 1);
    wr(REG_CTRL, ctl(4'd0, 0, 0, 0), 0);
    rd(REG_CTRL, v); check("R7 stop ignored", v, ctl(4'd0, 0, 1, 0));

    // R9 wrong signature
    wr(REG_UNLOCK, 8'h55, 0);
    rd(REG_UNLOCK, v); check("R9 unlock closed", v, 8'h00);
    wr(REG_CTRL, ctl(4'd0, 0, 0, 0), 0);
    rd(REG_CTRL, v); check("R9 stop ignored", v, ctl(4'd0, 0, 1, 0));

    // R13 / R8 protected stop on the last window cycle
    wr(REG_UNLOCK, SIG, 0);
    rd(REG_UNLOCK, v); check("R13 window flag", v, 8'h01);
    idle(3);
    wr(REG_CTRL, ctl(4'd0, 0, 0, 0), 0);
    rd(REG_CTRL, v); check("R8 stop accepted", v, 8'h00);
    rd(REG_UNLOCK, v); check("R10 window shut", v, 8'h00);
    pc = pulse_cnt;
    idle(20);
    check("R8 stopped no pulse", pulse_cnt, pc);

    // R8 window expired
    wr(REG_CTRL, ctl(4'd0, 0, 1, 0), 1);
    wr(REG_UNLOCK, SIG, 0);
    idle(4);
    rd(REG_UNLOCK, v); check("R8 window expired", v, 8'h00);
    wr(REG_CTRL, ctl(4'd0, 0, 0, 0), 0);
    rd(REG_CTRL, v); check("R8 late stop ignored", v, ctl(4'd0, 0, 1, 0));

    // R10 one write per signature
    wr(REG_UNLOCK, SIG, 0);
    wr(REG_CTRL, ctl(4'd0, 0, 1, 0), 1);
    wr(REG_CTRL, ctl(4'd0, 0, 0, 0), 0);
    rd(REG_CTRL, v); check("R10 second write unprotected", v, ctl(4'd0, 0, 1, 0));

    // R5 interrupt mode
    wr(REG_CTRL, ctl(4'd0, 1, 1, 0), 1);
    pc = pulse_cnt;
    idle(6);
    check("R5 irq raised", wdt_irq, 1);
    check("R5 no reset pulse", pulse_cnt, pc);
    wr(REG_CTRL, ctl(4'd0, 1, 1, 0), 1);
    rd(REG_CTRL, v); check("R5 write zero keeps flag", v, ctl(4'd0, 1, 1, 1));
    wr(REG_CTRL, ctl(4'd0, 1, 1, 1), 1);
    rd(REG_CTRL, v); check("R5 write one clears flag", v, ctl(4'd0, 1, 1, 0));
    check("R5 irq low", wdt_irq, 0);

    // level 2
    rst_n = 0; fuse_lvl2 = 1;
    idle(2);
    rst_n = 1;
    rd(REG_CTRL, v); check("R1 level2 ctrl", v, ctl(4'd0, 0, 1, 0));
    wr(REG_CTRL, ctl(4'd3, 1, 0, 0), 1);
    rd(REG_CTRL, v); check("R11 unprotected write ignored", v, ctl(4'd0, 0, 1, 0));
    measure("R11 still running", 4);
    wr(REG_UNLOCK, SIG, 0);
    wr(REG_CTRL, ctl(4'd3, 0, 0, 0), 1);
    rd(REG_CTRL, v); check("R12 protected period", v, ctl(4'd3, 0, 1, 0));
    measure("R12 new latency", 32);

    finish_run();
  end
endmodule